// File: doc/BRIEF.md
# Approximate Hybrid-Radix Signed Multiplier

This block multiplies two signed two's-complement operands and returns a double-width signed product. The product is an approximation, traded for fewer partial-product rows and simpler row selection. Operand `b` is recoded in two sections. Above bit K, each pair of bits becomes an exact radix-4 Booth digit in {0, ±1, ±2}. The lowest K bits are treated as one signed digit, and its magnitude is snapped to the nearest of four powers of two. That row therefore only ever needs a shifted copy of `a`, and no odd multiple has to be generated.

Negative rows are formed by inverting the selected multiple and adding a single one at the row's lowest weight. Sign extension is replaced by flipping each row's top bit and adding one precomputed correction constant. All rows, the injected ones and the constant are compressed exactly by a layered 3:2 carry-save tree. A parallel-prefix adder then resolves the last two vectors. The result is registered once, so it appears one clock after the operands. K is fixed at elaboration and sets how much accuracy is given up.

Top module: `ahm_mult`

## Requirements
- R1: While `rst_i` is high at a rising clock edge, `p_o` becomes zero at that edge, whatever values `a_i` and `b_i` hold.
- R2: With `rst_i` low, `p_o` after a rising edge holds the product of the operands present at that edge, and it stays unchanged until the next edge.
- R3: When `b_i[K-1:0]` is all zeros, `p_o` equals the exact signed product `a_i * b_i`.
- R4: Bits `b_i[N-1:K]` are recoded into (N-K)/2 radix-4 Booth digits from overlapping 3-bit windows, and the lowest window uses bit K-1 as its reference bit. Together these digits contribute exactly `a * (b - L)`, where L is the signed value of `b_i[K-1:0]` with bit K-1 weighted as -2^(K-1).
- R5: Let m = |L|. If m < 2^(K-5), the low digit contributes zero. Otherwise m is replaced by the nearest value in {2^(K-4), 2^(K-3), 2^(K-2), 2^(K-1)}, and the sign of L is kept.
- R6: The low row is always 0 or ±2^e·a with K-4 <= e <= K-1. For K=6 this is ±4a, ±8a, ±16a or ±32a; for K=8 it is ±16a through ±128a. When m is already one of these powers, the low row is exact.
- R7: Halfway cases round to the larger power. The magnitudes 2^(K-5), 3·2^(K-5), 3·2^(K-4) and 3·2^(K-3) become 2^(K-4), 2^(K-3), 2^(K-2) and 2^(K-1) respectively.
- R8: Apart from the rounding of the low digit, the arithmetic is exact. `p_o` equals `a * (b - L + round(L))` taken as a 2N-bit two's-complement value, for every sign combination, including the most negative value of either operand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous active-high reset of the product register |
| a_i | input | N | Signed multiplicand, used in shifted copies |
| b_i | input | N | Signed multiplier, recoded into Booth and high-radix digits |
| p_o | output | 2N | Registered signed approximate product |

## Verification
Two kinds of negation can occur in the same row sum. One is the low high-radix row, which is negated when the low K bits are negative. The other is a negated top Booth row, which occurs when `b` is near its most negative value. When both occur, the low row's injected one, the Booth row's injected one and the shared sign-correction constant all land in the same carry-save sum. The 8-bit, K=6 instance is swept over every operand pair, so each combination of low-digit sign, tie magnitude and negated Booth row is provoked. A wider K=8 instance is swept over every `b` with chosen `a` values. Each result is judged against an arithmetic model that rounds the low digit by the stated rule and multiplies in plain integers.

// File: rtl/ahm_pkg.sv
package ahm_pkg;

  // Booth digit of the exact section: value = (neg ? -1 : 1) * (two ? 2 : one ? 1 : 0)
  typedef struct packed {
    logic neg;
    logic one;
    logic two;
  } hi_dig_t;

  // High-radix low digit: pick[i] selects 2^(K-4+i); pick == 0 means zero digit
  typedef struct packed {
    logic       neg;
    logic [3:0] pick;
  } lo_dig_t;

  // Number of vectors left after lvl layers of 3:2 compression
  function automatic int tree_count(int ops, int lvl);
    int c;
    c = ops;
    for (int l = 0; l < lvl; l++) c = 2 * (c / 3) + (c % 3);
    return c;
  endfunction

  // Layers needed to bring ops vectors down to two
  function automatic int tree_levels(int ops);
    int c, l;
    c = ops;
    l = 0;
    while (c > 2) begin
      c = 2 * (c / 3) + (c % 3);
      l++;
    end
    return l;
  endfunction

endpackage

// File: rtl/ahm_recoder.sv
module ahm_recoder import ahm_pkg::*; #(
  parameter int N = 16,
  parameter int K = 8
) (
  input  logic                        [N-1:0] y_i,
  output hi_dig_t [(N-K)/2-1:0]               hi_o,
  output lo_dig_t                             lo_o
);
  localparam int H = (N - K) / 2;
  localparam logic [K-1:0] TH_MIN = K'(2 ** (K - 5));
  localparam logic [K-1:0] TH_1   = K'(3 * 2 ** (K - 5));
  localparam logic [K-1:0] TH_2   = K'(3 * 2 ** (K - 4));
  localparam logic [K-1:0] TH_3   = K'(3 * 2 ** (K - 3));

  // exact radix-4 section, windows anchored on bit K-1
  for (genvar j = 0; j < H; j++) begin : g_hi
    logic [2:0] win;
    assign win        = y_i[K+2*j+1 -: 3];
    assign hi_o[j].neg = win[2] & ~(win[1] & win[0]);
    assign hi_o[j].one = win[1] ^ win[0];
    assign hi_o[j].two = (win[2] & ~win[1] & ~win[0]) | (~win[2] & win[1] & win[0]);
  end

  // low high-radix digit, magnitude snapped to a power of two
  logic [K-1:0] lo_bits, lo_mag;
  assign lo_bits = y_i[K-1:0];
  assign lo_mag  = lo_bits[K-1] ? (~lo_bits + K'(1)) : lo_bits;

  always_comb begin
    if (lo_mag < TH_MIN)    lo_o.pick = 4'b0000;
    else if (lo_mag < TH_1) lo_o.pick = 4'b0001;
    else if (lo_mag < TH_2) lo_o.pick = 4'b0010;
    else if (lo_mag < TH_3) lo_o.pick = 4'b0100;
    else                    lo_o.pick = 4'b1000;
    lo_o.neg = lo_bits[K-1] & (lo_mag >= TH_MIN);
  end

  always_comb begin : chk_recode
    int acc, d, m, p;
    acc = int'($signed(lo_bits));
    for (int j2 = 0; j2 < H; j2++) begin
      d = hi_o[j2].two ? 2 : (hi_o[j2].one ? 1 : 0);
      if (hi_o[j2].neg) d = -d;
      acc = acc + d * (1 << (K + 2 * j2));
    end
    AST_HI_SPAN: assert (acc == int'($signed(y_i)))
      else $error("Booth digits plus low value do not rebuild the operand"); // R4
    m = int'(lo_mag);
    p = 0;
    for (int i = 0; i < 4; i++) if (lo_o.pick[i]) p = 1 << (K - 4 + i);
    AST_LO_ROUND: assert ((p == 0) ? (2 * m < (1 << (K - 4))) : ((2 * m >= p) && (2 * m < 3 * p)))
      else $error("low digit power is not near its magnitude"); // R5
  end

endmodule

// File: rtl/ahm_ppgen.sv
module ahm_ppgen import ahm_pkg::*; #(
  parameter int N = 16,
  parameter int K = 8
) (
  input  logic    [N-1:0]                        a_i,
  input  hi_dig_t [(N-K)/2-1:0]                  hi_i,
  input  lo_dig_t                                lo_i,
  output logic    [(N-K)/2+2:0][2*N-1:0]         rows_o
);
  localparam int H = (N - K) / 2;
  localparam int W = 2 * N;
  localparam int NOPS = H + 3;

  // sum of the top-bit offsets of every row, subtracted once
  function automatic logic [W-1:0] corr_value();
    logic [W-1:0] c;
    c = '0;
    for (int j = 0; j < H; j++) c = c - (W'(1) << (K + 2 * j + N));
    c = c - (W'(1) << (K - 4 + N + 3));
    return c;
  endfunction
  localparam logic [W-1:0] CORR = corr_value();

  for (genvar j = 0; j < H; j++) begin : g_row
    logic [N:0] mult, flip;
    assign mult = hi_i[j].one ? {a_i[N-1], a_i} : (hi_i[j].two ? {a_i, 1'b0} : '0);
    assign flip = mult ^ {(N+1){hi_i[j].neg}};
    assign rows_o[j] = {{(N-1){1'b0}}, ~flip[N], flip[N-1:0]} << (K + 2 * j);
  end

  logic [N+3:0] a_ext, lmult, lflip;
  logic [W-1:0] lo_row, neg_vec;
  assign a_ext = {{4{a_i[N-1]}}, a_i};

  always_comb begin
    case (lo_i.pick)
      4'b0001: lmult = a_ext;
      4'b0010: lmult = a_ext << 1;
      4'b0100: lmult = a_ext << 2;
      4'b1000: lmult = a_ext << 3;
      default: lmult = '0;
    endcase
    lflip  = lmult ^ {(N+4){lo_i.neg}};
    lo_row = {{(N-4){1'b0}}, ~lflip[N+3], lflip[N+2:0]} << (K - 4);
    neg_vec = '0;
    neg_vec[K-4] = lo_i.neg;
    for (int j = 0; j < H; j++) neg_vec[K+2*j] = hi_i[j].neg;
  end

  assign rows_o[H]   = lo_row;
  assign rows_o[H+1] = neg_vec;
  assign rows_o[H+2] = CORR;

  always_comb begin : chk_rows
    logic [W-1:0] tot;
    longint dsum, d;
    tot = '0;
    for (int i = 0; i < NOPS; i++) tot = tot + rows_o[i];
    dsum = 0;
    for (int j = 0; j < H; j++) begin
      d = hi_i[j].two ? 2 : (hi_i[j].one ? 1 : 0);
      if (hi_i[j].neg) d = -d;
      dsum = dsum + d * (longint'(1) << (K + 2 * j));
    end
    for (int i = 0; i < 4; i++)
      if (lo_i.pick[i]) dsum = dsum + (lo_i.neg ? -(longint'(1) << (K - 4 + i)) : (longint'(1) << (K - 4 + i)));
    AST_ROWS_SUM: assert (tot == W'(longint'($signed(a_i)) * dsum))
      else $error("row sum differs from multiplicand times digit value"); // R8
  end

endmodule

// File: rtl/ahm_csa_tree.sv
module ahm_csa_tree import ahm_pkg::*; #(
  parameter int W    = 32,
  parameter int NOPS = 7
) (
  input  logic [NOPS-1:0][W-1:0] ops_i,
  output logic [W-1:0]           sum_o,
  output logic [W-1:0]           carry_o
);
  localparam int LEVELS = tree_levels(NOPS);

  for (genvar l = 0; l <= LEVELS; l++) begin : g_lvl
    localparam int C = tree_count(NOPS, l);
    logic [W-1:0] v [C];
    if (l == 0) begin : g_in
      for (genvar i = 0; i < C; i++) begin : g_cp
        assign v[i] = ops_i[i];
      end
    end else begin : g_red
      localparam int PC = tree_count(NOPS, l - 1);
      localparam int G  = PC / 3;
      localparam int R  = PC % 3;
      for (genvar g = 0; g < G; g++) begin : g_fa
        logic [W-1:0] x0, x1, x2;
        assign x0 = g_lvl[l-1].v[3*g];
        assign x1 = g_lvl[l-1].v[3*g+1];
        assign x2 = g_lvl[l-1].v[3*g+2];
        assign v[2*g]   = x0 ^ x1 ^ x2;
        assign v[2*g+1] = ((x0 & x1) | (x0 & x2) | (x1 & x2)) << 1;
      end
      for (genvar r = 0; r < R; r++) begin : g_pass
        assign v[2*G+r] = g_lvl[l-1].v[3*G+r];
      end
    end
  end

  assign sum_o   = g_lvl[LEVELS].v[0];
  assign carry_o = g_lvl[LEVELS].v[1];

  always_comb begin : chk_tree
    logic [W-1:0] tot;
    tot = '0;
    for (int i = 0; i < NOPS; i++) tot = tot + ops_i[i];
    AST_CSA_KEEP: assert (tot == sum_o + carry_o)
      else $error("carry-save tree lost value"); // R8
  end

endmodule

// File: rtl/ahm_prefix_add.sv
module ahm_prefix_add #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] s_o
);
  localparam int ST = $clog2(W);

  logic [W-1:0] gs [ST+1];
  logic [W-1:0] ps [ST];

  assign gs[0] = a_i & b_i;
  assign ps[0] = a_i ^ b_i;

  for (genvar s = 0; s < ST; s++) begin : g_stage
    localparam int D = 1 << s;
    for (genvar i = 0; i < W; i++) begin : g_bit
      if (i >= D) begin : g_mrg
        assign gs[s+1][i] = gs[s][i] | (ps[s][i] & gs[s][i-D]);
        if (s + 1 < ST) begin : g_p
          assign ps[s+1][i] = ps[s][i] & ps[s][i-D];
        end
      end else begin : g_cpy
        assign gs[s+1][i] = gs[s][i];
        if (s + 1 < ST) begin : g_p
          assign ps[s+1][i] = ps[s][i];
        end
      end
    end
  end

  assign s_o = ps[0] ^ {gs[ST][W-2:0], 1'b0};

  always_comb begin
    AST_ADD_EXACT: assert ({gs[ST][W-1], s_o} == {1'b0, a_i} + {1'b0, b_i})
      else $error("prefix adder sum or carry wrong"); // R8
  end

endmodule

// File: rtl/ahm_mult.sv
module ahm_mult import ahm_pkg::*; #(
  parameter int N = 16,
  parameter int K = 8
) (
  input  logic           clk_i,
  input  logic           rst_i,
  input  logic [N-1:0]   a_i,
  input  logic [N-1:0]   b_i,
  output logic [2*N-1:0] p_o
);
  localparam int W    = 2 * N;
  localparam int H    = (N - K) / 2;
  localparam int NOPS = H + 3;

  if (K < 6 || K > N - 2 || ((N - K) % 2) != 0) begin : g_bad_cfg
    $error("K must be at least 6, at most N-2, with N-K even");
  end

  hi_dig_t [H-1:0]         hi;
  lo_dig_t                 lo;
  logic [NOPS-1:0][W-1:0]  rows;
  logic [W-1:0]            vsum, vcar, prod;

  ahm_recoder #(.N(N), .K(K)) u_rec (
    .y_i (b_i),
    .hi_o(hi),
    .lo_o(lo)
  );

  ahm_ppgen #(.N(N), .K(K)) u_ppg (
    .a_i   (a_i),
    .hi_i  (hi),
    .lo_i  (lo),
    .rows_o(rows)
  );

  ahm_csa_tree #(.W(W), .NOPS(NOPS)) u_tree (
    .ops_i  (rows),
    .sum_o  (vsum),
    .carry_o(vcar)
  );

  ahm_prefix_add #(.W(W)) u_add (
    .a_i(vsum),
    .b_i(vcar),
    .s_o(prod)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) p_o <= '0;
    else       p_o <= prod;
  end

  AST_RESET_CLEARS: assert property (@(posedge clk_i) rst_i |=> (p_o == '0)); // R1

  AST_EXACT_LOW_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (b_i[K-1:0] == '0) |=> (p_o == W'(longint'($signed($past(a_i))) * longint'($signed($past(b_i)))))); // R3

endmodule

// File: tb/tb_ahm_mult.sv
module tb_ahm_mult;
  localparam int CLK_PERIOD = 10;
  localparam int N0 = 8;
  localparam int K0 = 6;
  localparam int N1 = 12;
  localparam int K1 = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [N0-1:0]     a0, b0;
  logic [N1-1:0]     a1, b1;
  logic [2*N0-1:0]   p0;
  logic [2*N1-1:0]   p1;
  int                checks = 0;
  int                fails = 0;
  bit                done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ahm_mult #(.N(N0), .K(K0)) dut (
    .clk_i(clk), .rst_i(rst), .a_i(a0), .b_i(b0), .p_o(p0)
  );

  ahm_mult #(.N(N1), .K(K1)) dut_wide (
    .clk_i(clk), .rst_i(rst), .a_i(a1), .b_i(b1), .p_o(p1)
  );

  function automatic int low_val(int b, int k);
    int lo;
    lo = b & ((1 << k) - 1);
    if (lo >= (1 << (k - 1))) lo = lo - (1 << k);
    return lo;
  endfunction

  function automatic int approx_ref(int a, int b, int k);
    int lo, m, u, p;
    lo = low_val(b, k);
    m  = (lo < 0) ? -lo : lo;
    u  = 1 << (k - 5);
    if (m < u)           p = 0;
    else if (m < 3 * u)  p = 2 * u;
    else if (m < 6 * u)  p = 4 * u;
    else if (m < 12 * u) p = 8 * u;
    else                 p = 16 * u;
    return a * ((b - lo) + ((lo < 0) ? -p : p));
  endfunction

  function automatic string tag_of(int a, int b, int n, int k);
    int lo, m, u;
    lo = low_val(b, k);
    m  = (lo < 0) ? -lo : lo;
    u  = 1 << (k - 5);
    if (lo == 0) return "R3";
    if (m == u || m == 3 * u || m == 6 * u || m == 12 * u) return "R7";
    if (m < u) return "R5";
    if (m == 2 * u || m == 4 * u || m == 8 * u || m == 16 * u) return "R6";
    if (a == -(1 << (n - 1)) || b == -(1 << (n - 1))) return "R8";
    return "R4";
  endfunction

  task automatic check(string req, string what, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic apply(logic [N0-1:0] x0, logic [N0-1:0] y0,
                       logic [N1-1:0] x1, logic [N1-1:0] y1);
    int sa0, sb0, sa1, sb1;
    a0 = x0; b0 = y0; a1 = x1; b1 = y1;
    sa0 = int'($signed(x0)); sb0 = int'($signed(y0));
    sa1 = int'($signed(x1)); sb1 = int'($signed(y1));
    @(posedge clk);
    #1;
    check(tag_of(sa0, sb0, N0, K0), "k6 product", int'($signed(p0)), approx_ref(sa0, sb0, K0));
    check(tag_of(sa1, sb1, N1, K1), "k8 product", int'($signed(p1)), approx_ref(sa1, sb1, K1));
  endtask

  function automatic int a_pick(int idx);
    case (idx)
      0: return 0;      1: return 1;      2: return -1;     3: return 2;
      4: return -2;     5: return 2047;   6: return -2048;  7: return 3;
      8: return -3;     9: return 100;    10: return -100;  11: return 1365;
      12: return -1366; 13: return 7;     14: return -777;  default: return 512;
    endcase
  endfunction

  initial begin
    a0 = 8'd5; b0 = 8'd7; a1 = 12'd9; b1 = 12'd33;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "reset k6", int'(p0), 0);
    check("R1", "reset k8", int'(p1), 0);
    rst = 1'b0;

    for (int i = 0; i < 65536; i++) begin
      apply(N0'(i >> 8), N0'(i), N1'(a_pick(i >> 12)), N1'(i));
    end

    // latency and hold between edges
    a0 = 8'd3; b0 = 8'd64;
    @(posedge clk);
    #1;
    check("R2", "first result", int'($signed(p0)), 192);
    a0 = 8'hFB; b0 = 8'h80;
    #(CLK_PERIOD - 2);
    check("R2", "held until edge", int'($signed(p0)), 192);
    @(posedge clk);
    #1;
    check("R2", "second result", int'($signed(p0)), 640);

    // reset with live operands
    rst = 1'b1;
    a0 = 8'h7F; b0 = 8'h5A; a1 = 12'h7FF; b1 = 12'h5A5;
    @(posedge clk);
    #1;
    check("R1", "mid-run reset k6", int'(p0), 0);
    check("R1", "mid-run reset k8", int'(p1), 0);
    rst = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R2 watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule